// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial memory. Clock and data arrive oversampled in the system clock domain. The block finds start and stop conditions and decodes the address byte that follows a start. It then stores a sector of bytes into a small internal array, or returns bytes from that array. The data line is open drain, so the block only ever pulls it low, through an output enable.

The address byte has four fields, from the MSB down. The top bits hold a fixed device type. The next bits are select bits, checked against external pins; some of these are expected inverted. Below them are the high-order array address bits, and the LSB is the transfer direction.

A write carries one low address byte followed by data bytes. Each byte is stored at once, and only the low five address bits advance between bytes. A stop that closes a write with stored bytes starts a simulated program cycle of fixed length. During that cycle the block ignores the bus, so a master polls with address bytes until it is acknowledged. A separate protection block grants write permission through one input. Reads come in three forms: from the current counter, from an address set by a dummy write, or as a long sequential stream.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data-line enable `sdaOe` is low and the block waits for a start condition.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one clears the bit and byte progress and releases SDA. A partial byte followed by a new start does not disturb decoding of the next address byte.
- R3: The address byte is laid out as bits [7:5] device type 3'b101, bits [4:2] select field, bit [1] high array address bit A8, and bit [0] direction (1 = read, 0 = write). The select field must equal `selPins ^ 3'b010`. On a full match the block pulls SDA low in the ninth clock; otherwise it leaves SDA released and ignores the bus until the next start.
- R4: In a write, the byte after the address byte sets A7..A0 and is acknowledged. Each following data byte is acknowledged and stored. The address then advances in its low five bits only, wrapping inside its 32-byte sector.
- R5: A stop after at least one stored data byte starts a program cycle of `PROG_CYCLES` clocks. During that cycle no address byte is acknowledged and SDA is never driven. Afterwards the address is acknowledged again.
- R6: A read counter holds the address of the last byte sent plus one. A read-mode address byte with no preceding address returns the byte at that counter.
- R7: A dummy write (address byte, then low address byte, then a repeated start with a read-mode address byte) returns the byte at the written address. It starts no program cycle.
- R8: While the master acknowledges, reads continue with consecutive bytes. The counter advances across all address bits and wraps from 511 to 0.
- R9: A master NACK in the ninth clock of a read byte ends transmission. SDA stays released for any further clocks until the next start.
- R10: When `progEnable` is low, a data byte is neither acknowledged nor stored, and no program cycle follows.
- R11: The block changes `sdaOe` only while SCL is low.
- R12: A read-mode address byte does not load its A8 bit into the read counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level, as seen on the wired bus |
| sdaOe | output | 1 | Pull SDA low when high (open-drain enable) |
| selPins | input | 3 | Board-strapped select pins |
| progEnable | input | 1 | Write permission from the protection block |

## Verification
The address decoder is driven with the matching byte, with the select field set to the raw pin value instead of its inverted form, and with a wrong device type. This separates a correct inversion mask from a plain compare. Writes begin near the end of a sector, and the readback at the sector base shows that only the low five bits wrap. Other reads begin at the top of the array and show that the read counter carries through every bit. The bench also polls right after a stop, after a dummy write and after a refused write. This shows that only a stop that stored data makes the block go silent, and that it stays silent for at least the program cycle length.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } busState_e;

  // strobes from control to datapath, at most one address action per cycle
  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic relBus;
  } dpStrobe_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[g] <= 1'b1;
            sdaPipe[g] <= 1'b1;
          end else begin
            sclPipe[g] <= sclPipe[g-1];
            sdaPipe[g] <= sdaPipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl   = sclPipe[SYNC_STAGES-1];
  assign sdaLvl   = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/twi_mem_dp.sv
module twi_mem_dp
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int SECTOR_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       sdaLvl,
  output logic [7:0] rxByte,
  output logic       sdaOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]        memArr [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [6:0]        txRest;
  logic [7:0]        rdByte;

  assign rdByte = memArr[curAddr];

  always_ff @(posedge clk) begin
    if (stb.writeByte) memArr[curAddr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      curAddr <= '0;
      txRest  <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaLvl};

      if (stb.loadHi)
        curAddr[ADDR_W-1:8] <= rxByte[HI_W:1];
      else if (stb.loadLo)
        curAddr[7:0] <= rxByte;
      else if (stb.writeByte)
        curAddr <= {curAddr[ADDR_W-1:SECTOR_W], curAddr[SECTOR_W-1:0] + 1'b1};
      else if (stb.loadTx)
        curAddr <= curAddr + 1'b1;

      if (stb.loadTx) begin
        txRest <= rdByte[6:0];
        sdaOe  <= ~rdByte[7];
      end else if (stb.shiftTx) begin
        sdaOe  <= ~txRest[6];
        txRest <= {txRest[5:0], 1'b0};
      end else if (stb.ackOn) begin
        sdaOe <= 1'b1;
      end else if (stb.relBus) begin
        sdaOe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
#(
  parameter int                ADDR_W      = 9,
  parameter int                SEL_W       = 3,
  parameter logic [SEL_W-1:0]  SEL_INV     = 3'b010,
  parameter int                DEV_TYPE    = 5,
  parameter int                PROG_CYCLES = 2000,
  localparam int               HI_W        = ADDR_W - 8,
  localparam int               TAG_W       = 7 - HI_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic             sdaLvl,
  input  logic [TAG_W-1:0] devTag,
  input  logic             rwBit,
  input  logic [SEL_W-1:0] selPins,
  input  logic             progEnable,
  output dpStrobe_t        stb,
  output logic             busy
);

  localparam int TYPE_W = TAG_W - SEL_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  busState_e   state, stN;
  logic [3:0]  bitCnt, cntN;
  logic        rwFlag, rwN;
  logic        mAck, ackN;
  logic        dirty, dirtyN;
  logic [CNT_W-1:0] busyCnt, busyN;
  logic [SEL_W-1:0] selExp;
  logic        devMatch;

  genvar g;
  generate
    for (g = 0; g < SEL_W; g++) begin : gSel
      assign selExp[g] = selPins[g] ^ SEL_INV[g];
    end
  endgenerate

  assign devMatch = (devTag[TAG_W-1 -: TYPE_W] == TYPE_W'(DEV_TYPE)) &&
                    (devTag[SEL_W-1:0] == selExp);
  assign busy = (busyCnt != '0);

  always_comb begin
    stb    = '0;
    stN    = state;
    cntN   = bitCnt;
    rwN    = rwFlag;
    ackN   = mAck;
    dirtyN = dirty;
    busyN  = busy ? busyCnt - 1'b1 : busyCnt;

    if (busy) begin
      stN  = ST_IDLE;
      cntN = '0;
    end else if (stopDet) begin
      stb.relBus = 1'b1;
      stN  = ST_IDLE;
      cntN = '0;
      if (dirty) busyN = CNT_W'(PROG_CYCLES);
      dirtyN = 1'b0;
    end else if (startDet) begin
      stb.relBus = 1'b1;
      stN  = ST_DEV;
      cntN = '0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          cntN = bitCnt + 4'd1;
          if (state != ST_RDATA) stb.shiftIn = 1'b1;
        end else if (bitCnt == 4'd8) begin
          cntN = 4'd9;
          if (state == ST_RDATA) ackN = ~sdaLvl;
        end
      end else if (sclFall) begin
        if (state == ST_RDATA) begin
          if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
            stb.shiftTx = 1'b1;
          end else if (bitCnt == 4'd8) begin
            stb.relBus = 1'b1;
          end else if (bitCnt == 4'd9) begin
            cntN = '0;
            if (mAck) stb.loadTx = 1'b1;
            else      stN = ST_IDLE;
          end
        end else if (bitCnt == 4'd8) begin
          unique case (state)
            ST_DEV: begin
              if (devMatch) begin
                stb.ackOn = 1'b1;
                rwN = rwBit;
                if (!rwBit) stb.loadHi = 1'b1;
              end else begin
                stN  = ST_IDLE;
                cntN = '0;
              end
            end
            ST_WADDR: begin
              stb.ackOn  = 1'b1;
              stb.loadLo = 1'b1;
            end
            ST_WDATA: begin
              if (progEnable) begin
                stb.ackOn     = 1'b1;
                stb.writeByte = 1'b1;
                dirtyN        = 1'b1;
              end else begin
                stN  = ST_IDLE;
                cntN = '0;
              end
            end
            default: ;
          endcase
        end else if (bitCnt == 4'd9) begin
          stb.relBus = 1'b1;
          cntN = '0;
          unique case (state)
            ST_DEV: begin
              if (rwFlag) begin
                stN = ST_RDATA;
                stb.loadTx = 1'b1;
              end else begin
                stN = ST_WADDR;
              end
            end
            ST_WADDR: stN = ST_WDATA;
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rwFlag  <= 1'b0;
      mAck    <= 1'b0;
      dirty   <= 1'b0;
      busyCnt <= '0;
    end else begin
      state   <= stN;
      bitCnt  <= cntN;
      rwFlag  <= rwN;
      mAck    <= ackN;
      dirty   <= dirtyN;
      busyCnt <= busyN;
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int               ADDR_W      = 9,
  parameter int               SECTOR_W    = 5,
  parameter int               SEL_W       = 3,
  parameter logic [SEL_W-1:0] SEL_INV     = 3'b010,
  parameter int               DEV_TYPE    = 5,
  parameter int               PROG_CYCLES = 2000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [SEL_W-1:0] selPins,
  input  logic             progEnable
);

  localparam int HI_W = ADDR_W - 8;

  logic      sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic      busy;
  logic [7:0] rxByte;
  dpStrobe_t stb;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  twi_mem_ctrl #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_INV(SEL_INV),
    .DEV_TYPE(DEV_TYPE), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .devTag(rxByte[7:HI_W+1]), .rwBit(rxByte[0]),
    .selPins(selPins), .progEnable(progEnable), .stb(stb), .busy(busy)
  );

  twi_mem_dp #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sdaOe,
  input logic busy,
  input logic sclLvl,
  input logic stopDet,
  input logic startDet
);

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet));

  // R11
  scl_low_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .busy(busy),
  .sclLvl(sclLvl), .stopDet(stopDet), .startDet(startDet)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;

  localparam int PROG = 300;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] pins = 3'b011;
  logic progEn = 1'b1;
  logic sdaOe;
  logic sdaBus;
  int checks = 0;
  int fails = 0;
  int viol = 0;
  longint cyc = 0;
  logic prevOe = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  assign sdaBus = sdaM & ~sdaOe;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twi_mem_slave #(.PROG_CYCLES(PROG)) u_twi_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .selPins(pins), .progEnable(progEn)
  );

  // R11 monitor: slave-side changes must fall in SCL low
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclM) viol++;
    prevOe <= sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devB(input bit hi, input bit rw);
    return {3'b101, pins ^ 3'b010, hi, rw};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q / 2);
    ack = ~sdaBus;
    tick(Q / 2); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q / 2);
      b[i] = sdaBus;
      tick(Q / 2); sclM = 1'b0; tick(Q);
    end
    sdaM = ~ackIt; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input bit hi, input logic [7:0] word, input int n, output int nAck);
    bit a;
    nAck = 0;
    busStart();
    sendByte(devB(hi, 1'b0), a); nAck += int'(a);
    sendByte(word, a); nAck += int'(a);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], a); nAck += int'(a);
    end
    busStop();
  endtask

  task automatic randRead(input bit hi, input logic [7:0] word, input int n);
    bit a;
    logic [7:0] b;
    busStart();
    sendByte(devB(hi, 1'b0), a);
    sendByte(word, a);
    busStart();
    sendByte(devB(hi, 1'b1), a);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      rbuf[k] = b;
    end
    busStop();
  endtask

  task automatic poll(output bit ack);
    busStart(); sendByte(devB(1'b0, 1'b0), ack); busStop();
  endtask

  task automatic waitReady(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 60; k++) begin
      poll(ok);
      if (ok) break;
    end
  endtask

  task automatic tReset();
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", int'(sdaOe), 0);
  endtask

  task automatic tSelect();
    bit a;
    busStart(); sendByte({3'b101, pins, 1'b0, 1'b0}, a); busStop();
    chk(!a, "R3 raw select pins must not match", int'(a), 0);
    busStart(); sendByte({3'b100, pins ^ 3'b010, 1'b0, 1'b0}, a); busStop();
    chk(!a, "R3 wrong device type", int'(a), 0);
    busStart(); sendByte(devB(1'b0, 1'b0), a); busStop();
    chk(a, "R3 matching address", int'(a), 1);
  endtask

  task automatic tRestart();
    bit a;
    busStart(); sendBits(8'hFF, 4);
    busStart(); sendByte(devB(1'b0, 1'b0), a); busStop();
    chk(a, "R2 repeated start after partial byte", int'(a), 1);
    busStart(); sendBits(devB(1'b0, 1'b0), 5); busStop();
    busStart(); sendByte(devB(1'b0, 1'b0), a); busStop();
    chk(a, "R2 stop after partial byte", int'(a), 1);
  endtask

  task automatic tWrite();
    int n;
    bit a;
    bit ok;
    longint t0;
    for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
    doWrite(1'b1, 8'h3C, 6, n);
    chk(n == 8, "R4 every write byte acknowledged", n, 8);
    t0 = cyc;
    poll(a);
    chk(!a, "R5 address refused right after stop", int'(a), 0);
    waitReady(ok);
    chk(ok && (cyc - t0) >= longint'(PROG - 2 * Q), "R5 ready only after program cycle",
        int'(cyc - t0), PROG);
    randRead(1'b1, 8'h3C, 4);
    for (int k = 0; k < 4; k++)
      chk(rbuf[k] == 8'hA0 + 8'(k), "R8 sequential readback / R4 store", rbuf[k], 8'hA0 + k);
    poll(a);
    chk(a, "R7 dummy write starts no program cycle", int'(a), 1);
    randRead(1'b1, 8'h20, 2);
    chk(rbuf[0] == 8'hA4 && rbuf[1] == 8'hA5, "R4 sector wrap to base",
        {rbuf[0], rbuf[1]}, 16'hA4A5);
  endtask

  task automatic tCurrent();
    bit a;
    logic [7:0] b;
    randRead(1'b1, 8'h3C, 1);
    chk(rbuf[0] == 8'hA0, "R7 random read", rbuf[0], 8'hA0);
    busStart(); sendByte(devB(1'b0, 1'b1), a); recvByte(1'b0, b); busStop();
    chk(a, "R6 read-mode address acknowledged", int'(a), 1);
    chk(b == 8'hA1, "R6 R12 current address read uses counter", b, 8'hA1);
  endtask

  task automatic tRoll();
    int n;
    bit ok;
    wbuf[0] = 8'h5A;
    doWrite(1'b1, 8'hFF, 1, n);
    waitReady(ok);
    wbuf[0] = 8'hC3;
    doWrite(1'b0, 8'h00, 1, n);
    waitReady(ok);
    randRead(1'b1, 8'hFF, 2);
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hC3, "R8 read counter rolls over to 0",
        {rbuf[0], rbuf[1]}, 16'h5AC3);
  endtask

  task automatic tNack();
    bit a;
    bit seen = 1'b0;
    logic [7:0] b;
    busStart(); sendByte(devB(1'b1, 1'b0), a); sendByte(8'h3C, a);
    busStart(); sendByte(devB(1'b1, 1'b1), a); recvByte(1'b0, b);
    for (int k = 0; k < 9; k++) begin
      sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
      if (sdaOe) seen = 1'b1;
      sclM = 1'b0; tick(Q);
      if (sdaOe) seen = 1'b1;
    end
    busStop();
    chk(!seen, "R9 SDA released after master NACK", int'(seen), 0);
  endtask

  task automatic tProtect();
    bit a1, a2, a3, a;
    progEn = 1'b0;
    busStart(); sendByte(devB(1'b1, 1'b0), a1); sendByte(8'h3C, a2); sendByte(8'hFF, a3); busStop();
    progEn = 1'b1;
    chk(a1 && a2 && !a3, "R10 data byte refused", {a1, a2, a3}, 3'b110);
    poll(a);
    chk(a, "R10 no program cycle after refused write", int'(a), 1);
    randRead(1'b1, 8'h3C, 1);
    chk(rbuf[0] == 8'hA0, "R10 array unchanged", rbuf[0], 8'hA0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    tReset();
    tSelect();
    tRestart();
    tWrite();
    tCurrent();
    tRoll();
    tNack();
    tProtect();
    chk(viol == 0, "R11 slave changed SDA while SCL high", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule